// File: doc/BRIEF.md
# Serial-to-SPI Transaction Bridge

This block connects a byte-wide host link to the SPI port of a serial flash. Each direction of the host link is a byte stream with a valid/ready handshake. The block waits idle until an arm pulse arrives. It then answers the host with a one-byte ready code and starts taking framed transactions. In each frame, the first byte is the number of bytes to send to the flash and the second byte is the number of bytes to fetch back. The outgoing bytes follow. The block drives the whole exchange as a single flash transaction, with chip select held low from the first bit sent to the last bit received. Each reply byte is forwarded to the host as it arrives.

A frame in which both counts are zero ends bridge mode and makes no SPI activity. The block then returns to idle until the next arm pulse. The SPI clock is the system clock divided by an even parameter. Data follows SPI mode 0. If the host stops taking reply bytes, the block holds the SPI clock before the next reply byte, so no data is lost.

Top module: `serbr_bridge`

## Requirements
- R1: While idle, chip select stays high, SCK stays low, no byte is offered to the host, and any received byte is accepted and discarded. A one-cycle pulse on `arm_i` enters bridge mode and sends the single byte 0x05 to the host.
- R2: In bridge mode, the first received byte of a frame is the write count and the second is the read count. Each is an unsigned value from 0 to 255.
- R3: The write-count payload bytes that follow the header are shifted out on MOSI in arrival order, most significant bit first, in SPI mode 0. SCK idles low, the flash samples on the rising edge, and MOSI changes only while SCK is low.
- R4: After the last write byte, exactly read-count bytes are clocked in from MISO, with 0x00 driven on MOSI. They are sent to the host in the order they were received.
- R5: For each frame with a nonzero count, chip select goes low exactly once, before the first SCK edge. It stays low through the last read byte and is high again before the next frame header is processed. SCK never pulses while chip select is high.
- R6: A frame with a nonzero write count and a zero read count ends after the last write byte and sends nothing to the host.
- R7: A frame of two zero bytes makes no SCK edge and no chip-select fall, and sends no byte to the host. It returns the block to idle (`active_o` low). A later arm pulse enters bridge mode again and sends 0x05 again.
- R8: While a reply byte is offered and the host is not ready, the byte and its valid stay stable and no further SCK rising edge occurs. Every reply byte reaches the host once the host becomes ready.
- R9: Within a byte, consecutive SCK rising edges are exactly CLK_DIV system clock cycles apart.
- R10: A read count of 255 returns all 255 bytes in order within one chip-select period.
- R11: A frame with a zero write count and a nonzero read count goes straight to the read phase, and the first reply is the first byte clocked in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Pulse that enters bridge mode from idle |
| rx_data_i | input | 8 | Byte from the host |
| rx_valid_i | input | 1 | Host byte is valid |
| rx_ready_o | output | 1 | Block accepts the host byte |
| tx_data_o | output | 8 | Byte to the host |
| tx_valid_o | output | 1 | Byte to the host is valid |
| tx_ready_i | input | 1 | Host accepts the byte |
| active_o | output | 1 | High while in bridge mode |
| spi_sck_o | output | 1 | SPI clock, idles low |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench uses a flash model that records every byte clocked in and returns a known sequence numbered by its byte position within the chip-select period. A frame with both writes and reads shows that the two counts are parsed in order and that the phases share one transaction. Write-only and read-only frames separate the two phase transitions from each other. A stalled host side shows that SCK pauses without dropping a reply byte, and a 255-byte read covers the largest count. The empty frame, together with bytes sent while idle, confirms that leaving the mode is clean and that idle traffic is ignored.

// File: rtl/serbr_pkg.sv
`timescale 1ns/1ps
package serbr_pkg;

   typedef logic [7:0] byte_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_READY,
      ST_WCNT,
      ST_RCNT,
      ST_WR_WAIT,
      ST_WR_SHIFT,
      ST_RD_START,
      ST_RD_SHIFT,
      ST_RD_SEND,
      ST_CS_END
   } br_state_t;

endpackage

// File: rtl/serbr_spi_engine.sv
`timescale 1ns/1ps
module serbr_spi_engine #(
   parameter int CLK_DIV = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  serbr_pkg::byte_t     data_i,
   output logic                 done_o,
   output serbr_pkg::byte_t     rdata_o,
   output logic                 sck_o,
   output logic                 mosi_o,
   input  logic                 miso_i
);
   localparam int HALF = CLK_DIV / 2;

   logic             busy_q;
   logic             sck_q;
   logic             done_q;
   logic [2:0]       bit_q;
   serbr_pkg::byte_t out_q;
   serbr_pkg::byte_t in_q;
   logic             tick;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (start_i || !busy_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(HALF - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = busy_q && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
         bit_q  <= '0;
         out_q  <= '0;
         in_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            out_q  <= data_i;
            bit_q  <= '0;
            sck_q  <= 1'b0;
         end else if (tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               in_q  <= {in_q[6:0], miso_i};
            end else begin
               sck_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  out_q <= {out_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign done_o  = done_q;
   assign rdata_o = in_q;
   assign sck_o   = sck_q;
   assign mosi_o  = out_q[7];

endmodule

// File: rtl/serbr_frame_ctrl.sv
`timescale 1ns/1ps
module serbr_frame_ctrl #(
   parameter logic [7:0] READY_CODE = 8'h05,
   parameter logic [7:0] FILL_BYTE  = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  serbr_pkg::byte_t rx_data_i,
   input  logic             rx_valid_i,
   output logic             rx_ready_o,
   output serbr_pkg::byte_t tx_data_o,
   output logic             tx_valid_o,
   input  logic             tx_ready_i,
   output logic             cs_n_o,
   output logic             active_o,
   output logic             eng_start_o,
   output serbr_pkg::byte_t eng_data_o,
   input  logic             eng_done_i,
   input  serbr_pkg::byte_t eng_rdata_i
);
   import serbr_pkg::*;

   br_state_t st_q;
   byte_t     wcnt_q;
   byte_t     wrem_q;
   byte_t     rrem_q;
   byte_t     txd_q;
   logic      cs_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         wcnt_q <= '0;
         wrem_q <= '0;
         rrem_q <= '0;
         txd_q  <= '0;
         cs_n_q <= 1'b1;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (arm_i) begin
                  txd_q <= READY_CODE;
                  st_q  <= ST_READY;
               end
            end
            ST_READY: begin
               if (tx_ready_i) st_q <= ST_WCNT;
            end
            ST_WCNT: begin
               if (rx_valid_i) begin
                  wcnt_q <= rx_data_i;
                  st_q   <= ST_RCNT;
               end
            end
            ST_RCNT: begin
               if (rx_valid_i) begin
                  if ((wcnt_q == 8'd0) && (rx_data_i == 8'd0)) begin
                     st_q <= ST_IDLE;
                  end else begin
                     rrem_q <= rx_data_i;
                     wrem_q <= wcnt_q;
                     cs_n_q <= 1'b0;
                     st_q   <= (wcnt_q != 8'd0) ? ST_WR_WAIT : ST_RD_START;
                  end
               end
            end
            ST_WR_WAIT: begin
               if (rx_valid_i) begin
                  wrem_q <= wrem_q - 1'b1;
                  st_q   <= ST_WR_SHIFT;
               end
            end
            ST_WR_SHIFT: begin
               if (eng_done_i) begin
                  if (wrem_q != 8'd0)      st_q <= ST_WR_WAIT;
                  else if (rrem_q != 8'd0) st_q <= ST_RD_START;
                  else                     st_q <= ST_CS_END;
               end
            end
            ST_RD_START: begin
               st_q <= ST_RD_SHIFT;
            end
            ST_RD_SHIFT: begin
               if (eng_done_i) begin
                  txd_q  <= eng_rdata_i;
                  rrem_q <= rrem_q - 1'b1;
                  st_q   <= ST_RD_SEND;
               end
            end
            ST_RD_SEND: begin
               if (tx_ready_i) st_q <= (rrem_q != 8'd0) ? ST_RD_START : ST_CS_END;
            end
            ST_CS_END: begin
               cs_n_q <= 1'b1;
               st_q   <= ST_WCNT;
            end
            default: begin
               st_q   <= ST_IDLE;
               cs_n_q <= 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      rx_ready_o = (st_q == ST_IDLE) || (st_q == ST_WCNT) ||
                   (st_q == ST_RCNT) || (st_q == ST_WR_WAIT);
      tx_valid_o = (st_q == ST_READY) || (st_q == ST_RD_SEND);
      eng_start_o = ((st_q == ST_WR_WAIT) && rx_valid_i) || (st_q == ST_RD_START);
      eng_data_o  = (st_q == ST_RD_START) ? FILL_BYTE : rx_data_i;
   end

   assign tx_data_o = txd_q;
   assign cs_n_o    = cs_n_q;
   assign active_o  = (st_q != ST_IDLE);

endmodule

// File: rtl/serbr_bridge.sv
`timescale 1ns/1ps
module serbr_bridge #(
   parameter int         CLK_DIV    = 4,
   parameter logic [7:0] READY_CODE = 8'h05,
   parameter logic [7:0] FILL_BYTE  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm_i,
   input  logic [7:0] rx_data_i,
   input  logic       rx_valid_i,
   output logic       rx_ready_o,
   output logic [7:0] tx_data_o,
   output logic       tx_valid_o,
   input  logic       tx_ready_i,
   output logic       active_o,
   output logic       spi_sck_o,
   output logic       spi_cs_n_o,
   output logic       spi_mosi_o,
   input  logic       spi_miso_i
);
   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("serbr_bridge: CLK_DIV must be an even value of at least 2");
      end
   endgenerate

   logic             eng_start;
   serbr_pkg::byte_t eng_data;
   logic             eng_done;
   serbr_pkg::byte_t eng_rdata;

   serbr_frame_ctrl #(
      .READY_CODE (READY_CODE),
      .FILL_BYTE  (FILL_BYTE)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_i),
      .rx_data_i   (rx_data_i),
      .rx_valid_i  (rx_valid_i),
      .rx_ready_o  (rx_ready_o),
      .tx_data_o   (tx_data_o),
      .tx_valid_o  (tx_valid_o),
      .tx_ready_i  (tx_ready_i),
      .cs_n_o      (spi_cs_n_o),
      .active_o    (active_o),
      .eng_start_o (eng_start),
      .eng_data_o  (eng_data),
      .eng_done_i  (eng_done),
      .eng_rdata_i (eng_rdata)
   );

   serbr_spi_engine #(
      .CLK_DIV (CLK_DIV)
   ) eng_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (eng_start),
      .data_i  (eng_data),
      .done_o  (eng_done),
      .rdata_o (eng_rdata),
      .sck_o   (spi_sck_o),
      .mosi_o  (spi_mosi_o),
      .miso_i  (spi_miso_i)
   );

endmodule

// File: rtl/serbr_bridge_chk.sv
`timescale 1ns/1ps
module serbr_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       active_o,
   input logic       spi_sck_o,
   input logic       spi_cs_n_o,
   input logic       spi_mosi_o,
   input logic       tx_valid_o,
   input logic       tx_ready_i,
   input logic [7:0] tx_data_o
);

   p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> spi_cs_n_o);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> !tx_valid_o);

   p_sck_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_sck_o);

   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

   p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   p_stall_nosck_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> !$rose(spi_sck_o));

endmodule

bind serbr_bridge serbr_bridge_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .active_o   (active_o),
   .spi_sck_o  (spi_sck_o),
   .spi_cs_n_o (spi_cs_n_o),
   .spi_mosi_o (spi_mosi_o),
   .tx_valid_o (tx_valid_o),
   .tx_ready_i (tx_ready_i),
   .tx_data_o  (tx_data_o)
);

// File: tb/serbr_bridge_tb_top.sv
`timescale 1ns/1ps
module serbr_bridge_tb_top;
   localparam int CLK_DIV = 4;
   localparam int TCLK    = 20;

   logic       clk;
   logic       rst_n;
   logic       arm_i;
   logic [7:0] rx_data_i;
   logic       rx_valid_i;
   logic       rx_ready_o;
   logic [7:0] tx_data_o;
   logic       tx_valid_o;
   logic       tx_ready_i;
   logic       active_o;
   logic       spi_sck_o;
   logic       spi_cs_n_o;
   logic       spi_mosi_o;
   logic       spi_miso_i;

   serbr_bridge #(.CLK_DIV(CLK_DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
      .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o),
      .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
      .active_o(active_o), .spi_sck_o(spi_sck_o), .spi_cs_n_o(spi_cs_n_o),
      .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
   );

   initial clk = 1'b0;
   always #(TCLK/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'(8'hA0 + i);
   endfunction

   // Host receive collector
   logic [7:0] txq [0:1023];
   int ntx = 0;
   always @(posedge clk) begin
      if (rst_n && tx_valid_o && tx_ready_i && ntx < 1024) begin
         txq[ntx] = tx_data_o;
         ntx++;
      end
   end

   // Flash model: logs bytes seen on MOSI, returns pat(position) on MISO
   logic [7:0] flog [0:1023];
   int nflog = 0;
   int f_bit = 0;
   int f_idx = 0;
   logic [7:0] f_in = '0;
   logic [7:0] f_out = '0;
   int nrise = 0;
   int ncsf = 0;
   time t_last = 0;
   time min_gap = 0;

   initial spi_miso_i = 1'b0;

   always @(negedge spi_cs_n_o) begin
      ncsf++;
      f_bit = 0;
      f_idx = 0;
      f_out = pat(0);
      spi_miso_i = f_out[7];
   end

   always @(posedge spi_sck_o) begin
      nrise++;
      if (t_last != 0 && (min_gap == 0 || ($time - t_last) < min_gap))
         min_gap = $time - t_last;
      t_last = $time;
      if (spi_cs_n_o == 1'b0) begin
         f_in = {f_in[6:0], spi_mosi_o};
         f_bit++;
         if (f_bit == 8) begin
            if (nflog < 1024) flog[nflog] = f_in;
            nflog++;
            f_bit = 0;
            f_idx++;
         end
      end
   end

   always @(negedge spi_sck_o) begin
      if (spi_cs_n_o == 1'b0) begin
         if (f_bit == 0) f_out = pat(f_idx);
         else            f_out = {f_out[6:0], 1'b0};
         spi_miso_i = f_out[7];
      end
   end

   task automatic report_done();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      report_done();
   end

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid_i = 1'b1;
      rx_data_i  = b;
      for (int i = 0; i < 20000; i++) begin
         if (rx_ready_o) break;
         @(negedge clk);
      end
      @(posedge clk);
      #1;
      rx_valid_i = 1'b0;
   endtask

   task automatic wait_tx(input int n);
      for (int i = 0; i < 30000; i++) begin
         if (ntx >= n) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_cs_high();
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (spi_cs_n_o) break;
      end
   endtask

   task automatic pulse_arm();
      @(negedge clk);
      arm_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
   endtask

   logic [7:0] wbuf [0:255];

   // Generic frame: writes wbuf[0..w-1], expects r replies
   task automatic do_frame(input string tag, input int w, input int r);
      int f0, t0, c0, bad;
      f0 = nflog; t0 = ntx; c0 = ncsf;
      send_byte(8'(w));
      send_byte(8'(r));
      for (int i = 0; i < w; i++) send_byte(wbuf[i]);
      wait_tx(t0 + r);
      wait_cs_high();
      repeat (10) @(negedge clk);
      check(nflog - f0 == w + r, "R2", {tag, " bytes on SPI"}, nflog - f0, w + r);
      bad = 0;
      for (int i = 0; i < w; i++) if (flog[f0 + i] !== wbuf[i]) bad++;
      check(bad == 0, "R3", {tag, " write data mismatches"}, bad, 0);
      bad = 0;
      for (int i = 0; i < r; i++) if (flog[f0 + w + i] !== 8'h00) bad++;
      check(bad == 0, "R4", {tag, " MOSI fill during reads"}, bad, 0);
      check(ntx - t0 == r, "R4", {tag, " reply count"}, ntx - t0, r);
      bad = 0;
      for (int i = 0; i < r; i++) if (txq[t0 + i] !== pat(w + i)) bad++;
      check(bad == 0, "R4", {tag, " reply data mismatches"}, bad, 0);
      check(ncsf - c0 == 1, "R5", {tag, " chip-select falls"}, ncsf - c0, 1);
      check(spi_cs_n_o == 1'b1, "R5", {tag, " chip select after frame"}, spi_cs_n_o, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(spi_cs_n_o == 1'b1, "R1", "reset chip select", spi_cs_n_o, 1);
      check(spi_sck_o == 1'b0, "R9", "reset SCK", spi_sck_o, 0);
      check(tx_valid_o == 1'b0, "R1", "reset tx valid", tx_valid_o, 0);
      check(active_o == 1'b0, "R1", "reset active", active_o, 0);
   endtask

   task automatic t_idle_ignore();
      int r0, c0, t0;
      r0 = nrise; c0 = ncsf; t0 = ntx;
      send_byte(8'h02);
      send_byte(8'h01);
      send_byte(8'h55);
      repeat (20) @(negedge clk);
      check(nrise == r0, "R1", "idle SCK edges", nrise - r0, 0);
      check(ncsf == c0, "R1", "idle chip-select falls", ncsf - c0, 0);
      check(ntx == t0, "R1", "idle host bytes", ntx - t0, 0);
      check(active_o == 1'b0, "R1", "idle after traffic", active_o, 0);
   endtask

   task automatic t_arm();
      int t0;
      t0 = ntx;
      pulse_arm();
      wait_tx(t0 + 1);
      repeat (3) @(negedge clk);
      check(ntx - t0 == 1, "R1", "ready byte count", ntx - t0, 1);
      check(txq[t0] == 8'h05, "R1", "ready byte value", txq[t0], 8'h05);
      check(active_o == 1'b1, "R1", "active after arm", active_o, 1);
   endtask

   task automatic t_write_read();
      wbuf[0] = 8'hFE; wbuf[1] = 8'hFA;
      min_gap = 0; t_last = 0;
      do_frame("write+read", 2, 3);
      check(min_gap == CLK_DIV * TCLK, "R9", "SCK rise spacing ns",
            int'(min_gap), CLK_DIV * TCLK);
   endtask

   task automatic t_write_only();
      int t0;
      t0 = ntx;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      do_frame("write-only", 3, 0);
      repeat (20) @(negedge clk);
      check(ntx == t0, "R6", "write-only replies", ntx - t0, 0);
   endtask

   task automatic t_read_only();
      int t0;
      t0 = ntx;
      do_frame("read-only", 0, 2);
      check(txq[t0] == pat(0), "R11", "read-only first reply", txq[t0], pat(0));
   endtask

   task automatic t_stall();
      int t0, r0, bad;
      t0 = ntx;
      @(negedge clk);
      tx_ready_i = 1'b0;
      send_byte(8'h01);
      send_byte(8'h04);
      send_byte(8'h9C);
      for (int i = 0; i < 20000; i++) begin
         if (tx_valid_o) break;
         @(negedge clk);
      end
      r0 = nrise;
      repeat (100) @(negedge clk);
      check(nrise == r0, "R8", "SCK edges while stalled", nrise - r0, 0);
      check(spi_cs_n_o == 1'b0, "R5", "chip select held in stall", spi_cs_n_o, 0);
      check(tx_valid_o == 1'b1 && tx_data_o == pat(1), "R8", "held reply byte",
            tx_data_o, pat(1));
      tx_ready_i = 1'b1;
      wait_tx(t0 + 4);
      wait_cs_high();
      repeat (10) @(negedge clk);
      check(ntx - t0 == 4, "R8", "replies after stall", ntx - t0, 4);
      bad = 0;
      for (int i = 0; i < 4; i++) if (txq[t0 + i] !== pat(1 + i)) bad++;
      check(bad == 0, "R8", "reply order after stall", bad, 0);
   endtask

   task automatic t_big();
      wbuf[0] = 8'h5A;
      do_frame("max read R10", 1, 255);
   endtask

   task automatic t_exit();
      int r0, c0, t0;
      r0 = nrise; c0 = ncsf; t0 = ntx;
      send_byte(8'h00);
      send_byte(8'h00);
      repeat (20) @(negedge clk);
      check(active_o == 1'b0, "R7", "active after empty frame", active_o, 0);
      check(nrise == r0, "R7", "SCK edges on empty frame", nrise - r0, 0);
      check(ncsf == c0, "R7", "chip-select falls on empty frame", ncsf - c0, 0);
      check(ntx == t0, "R7", "replies on empty frame", ntx - t0, 0);
      t_idle_ignore();
      t0 = ntx;
      pulse_arm();
      wait_tx(t0 + 1);
      repeat (3) @(negedge clk);
      check(ntx - t0 == 1 && txq[t0] == 8'h05, "R7", "ready byte on re-arm",
            txq[t0], 8'h05);
   endtask

   initial begin
      rst_n      = 1'b0;
      arm_i      = 1'b0;
      rx_valid_i = 1'b0;
      rx_data_i  = '0;
      tx_ready_i = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle_ignore();
      t_arm();
      t_write_read();
      t_write_only();
      t_read_only();
      t_stall();
      t_big();
      t_exit();
      report_done();
   end

endmodule